// File: doc/BRIEF.md
# FPGA Slave-Serial Configuration Loader

This block brings up an SRAM-based FPGA that is configured over a slave-serial link. A host pulses `start_i`. The loader then asserts the active-low PROGRAM line and waits for the FPGA to pull INIT low. It releases PROGRAM and waits for INIT to return high. It then streams the bitstream, one byte at a time, onto the DIN pin under a generated configuration clock. After the final bit it waits for DONE. Each of the three waits has its own timeout and its own error code. The block then returns to idle and holds the result until the next start.

After a successful load the FPGA's user logic gets a two-phase reset. PROGRAM and CCLK stay high and DIN stays low for a hold interval, and then DIN is raised for a second hold interval. The bitstream arrives on a byte-wide valid/ready port, with a last flag on the final byte. Clock rate, timeouts and hold length are parameters counted in system clock cycles. The reset input is asserted asynchronously and released through a two-stage synchronizer, so the loader reacts from the third clock edge after `rst_n` rises.

Top module: `fpga_cfg_loader`

## Requirements
- R1: After reset the outputs are idle: `prog_o`=1, `cclk_o`=0, `din_o`=0, `ready_o`=0, `busy_o`=0 and `code_o`=0.
- R2: A start seen in idle gives one cycle with `prog_o` high, then holds `prog_o` low until INIT is sampled low. A start while busy has no effect on any output.
- R3: If INIT is not sampled low within T_INIT_LOW cycles of PROGRAM going low, the block returns to idle with `code_o`=1.
- R4: Once INIT is sampled low, `prog_o` returns high. If INIT is not sampled high within T_INIT_HIGH cycles, the block returns to idle with `code_o`=2.
- R5: Each byte is shifted most significant bit first. Every bit is placed on `din_o` while `cclk_o` is low for CCLK_HALF cycles, then held while `cclk_o` is high for CCLK_HALF cycles, so a receiver capturing on the rising CCLK edge sees the byte in order.
- R6: `ready_o` is high only in the data phase while no byte is being shifted. A byte is taken on a cycle with both `valid_i` and `ready_o` high, and its shifting starts the next cycle.
- R7: After the last bit of the byte flagged `last_i`, the block waits for DONE. If DONE is not sampled high within T_DONE cycles, it returns to idle with `code_o`=3.
- R8: When DONE is seen, the block drives `prog_o`=1, `cclk_o`=1, `din_o`=0 for HOLD_CYC cycles, then `din_o`=1 for another HOLD_CYC cycles, then returns to idle with `code_o`=0.
- R9: `busy_o` is high from the cycle after an accepted start until the return to idle. `code_o` is cleared by an accepted start and otherwise stays unchanged while idle.
- R10: When the awaited INIT or DONE level is sampled on the last cycle of its window, the handshake wins over the timeout. One cycle later, the timeout wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a configuration run (sampled in idle) |
| data_i | input | BYTE_W | Bitstream byte |
| valid_i | input | 1 | Byte on `data_i` is valid |
| last_i | input | 1 | Byte on `data_i` is the final one |
| ready_o | output | 1 | Loader can take a byte this cycle |
| prog_o | output | 1 | PROGRAM pin level, low = clear FPGA |
| cclk_o | output | 1 | Configuration clock to the FPGA |
| din_o | output | 1 | Serial configuration data to the FPGA |
| init_i | input | 1 | INIT pin level from the FPGA |
| done_i | input | 1 | DONE pin level from the FPGA |
| busy_o | output | 1 | Run in progress |
| code_o | output | 2 | Result: 0 ok, 1 INIT stuck high, 2 INIT stuck low, 3 no DONE |

## Verification
Within a single cycle, the awaited INIT or DONE level can arrive on the same edge at which its window counter expires. The bench places the INIT fall, the INIT rise and the DONE rise exactly on the final cycle of their windows, and in a second run one cycle later. The behavioural reference, compared on every clock, expects a clean load in the first run and error code 1 or 3 in the second. A start pulse injected during shifting is also compared cycle by cycle, to show that it alters nothing.

// File: rtl/fcl_pkg.sv
package fcl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PHI,
    ST_PLOW,
    ST_WIHI,
    ST_SHIFT,
    ST_WDONE,
    ST_HOLD_LO,
    ST_HOLD_HI
  } fcl_state_e;

  typedef enum logic [1:0] {
    RES_OK           = 2'd0,
    RES_NO_INIT_LOW  = 2'd1,
    RES_NO_INIT_HIGH = 2'd2,
    RES_NO_DONE      = 2'd3
  } fcl_res_e;

  function automatic int unsigned fcl_max(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fcl_wtimer.sv
// Window counter: cleared by the controller, flags the last cycle of a window.
module fcl_wtimer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic [CW-1:0] lim_i,
  output logic          hit_o
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit_o = (cnt_q == lim_i - 1'b1);

  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < lim_i); // R3

endmodule

// File: rtl/fcl_shifter.sv
// Byte serializer with its own configuration-clock generator.
module fcl_shifter #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned CCLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              last_i,
  output logic              empty_o,
  output logic              cclk_o,
  output logic              din_o,
  output logic              end_o
);

  localparam int unsigned HW = (CCLK_HALF > 1) ? $clog2(CCLK_HALF) : 1;
  localparam int unsigned BW = $clog2(BYTE_W + 1);

  logic              act_q, act_d;
  logic              cclk_q, cclk_d;
  logic              last_q, last_d;
  logic [HW-1:0]     hcnt_q, hcnt_d;
  logic [BW-1:0]     bcnt_q, bcnt_d;
  logic [BYTE_W-1:0] sreg_q, sreg_d;
  logic              half_end;

  assign half_end = act_q && (hcnt_q == HW'(CCLK_HALF - 1));

  always_comb begin
    act_d  = act_q;
    cclk_d = cclk_q;
    last_d = last_q;
    hcnt_d = hcnt_q;
    bcnt_d = bcnt_q;
    sreg_d = sreg_q;
    if (load_i && !act_q) begin
      act_d  = 1'b1;
      cclk_d = 1'b0;
      last_d = last_i;
      hcnt_d = '0;
      bcnt_d = BW'(BYTE_W);
      sreg_d = data_i;
    end else if (act_q) begin
      if (half_end) begin
        hcnt_d = '0;
        if (!cclk_q) begin
          cclk_d = 1'b1;
        end else begin
          cclk_d = 1'b0;
          sreg_d = {sreg_q[BYTE_W-2:0], 1'b0};
          bcnt_d = bcnt_q - 1'b1;
          if (bcnt_q == BW'(1)) act_d = 1'b0;
        end
      end else begin
        hcnt_d = hcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cclk_q <= 1'b0;
      last_q <= 1'b0;
      hcnt_q <= '0;
      bcnt_q <= '0;
      sreg_q <= '0;
    end else begin
      act_q  <= act_d;
      cclk_q <= cclk_d;
      last_q <= last_d;
      hcnt_q <= hcnt_d;
      bcnt_q <= bcnt_d;
      sreg_q <= sreg_d;
    end
  end

  assign empty_o = !act_q;
  assign cclk_o  = cclk_q;
  assign din_o   = act_q && sreg_q[BYTE_W-1];
  assign end_o   = half_end && cclk_q && (bcnt_q == BW'(1)) && last_q;

  AST_DIN_STABLE_CCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk_q && $past(cclk_q)) |-> $stable(din_o)); // R5

endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
  import fcl_pkg::*;
#(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned CCLK_HALF   = 2,
  parameter int unsigned T_INIT_LOW  = 1000,
  parameter int unsigned T_INIT_HIGH = 1000,
  parameter int unsigned T_DONE      = 1000,
  parameter int unsigned HOLD_CYC    = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              last_i,
  output logic              ready_o,
  output logic              prog_o,
  output logic              cclk_o,
  output logic              din_o,
  input  logic              init_i,
  input  logic              done_i,
  output logic              busy_o,
  output logic [1:0]        code_o
);

  localparam int unsigned MAXW =
    fcl_max(fcl_max(T_INIT_LOW, T_INIT_HIGH), fcl_max(T_DONE, HOLD_CYC));
  localparam int unsigned CW = $clog2(MAXW + 1);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  fcl_state_e    st_q, st_d;
  fcl_res_e      code_q, code_d;
  logic [CW-1:0] lim;
  logic          tmr_clr, tmr_hit;
  logic          sh_load, sh_empty, sh_cclk, sh_din, sh_end;

  // window length for the state being timed
  always_comb begin
    unique case (st_q)
      ST_PLOW:              lim = CW'(T_INIT_LOW);
      ST_WIHI:              lim = CW'(T_INIT_HIGH);
      ST_WDONE:             lim = CW'(T_DONE);
      ST_HOLD_LO, ST_HOLD_HI: lim = CW'(HOLD_CYC);
      default:              lim = CW'(1);
    endcase
  end

  assign tmr_clr = (st_d != st_q) || (st_q == ST_IDLE) || (st_q == ST_SHIFT);

  fcl_wtimer #(.CW(CW)) u_tmr (
    .clk   (clk),
    .rst_n (srst_n),
    .clr_i (tmr_clr),
    .lim_i (lim),
    .hit_o (tmr_hit)
  );

  assign sh_load = valid_i && ready_o;

  fcl_shifter #(.BYTE_W(BYTE_W), .CCLK_HALF(CCLK_HALF)) u_sh (
    .clk     (clk),
    .rst_n   (srst_n),
    .load_i  (sh_load),
    .data_i  (data_i),
    .last_i  (last_i),
    .empty_o (sh_empty),
    .cclk_o  (sh_cclk),
    .din_o   (sh_din),
    .end_o   (sh_end)
  );

  // sequencer: the awaited level is tested before the window expiry
  always_comb begin
    st_d   = st_q;
    code_d = code_q;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d   = ST_PHI;
        code_d = RES_OK;
      end
      ST_PHI: st_d = ST_PLOW;
      ST_PLOW: begin
        if (!init_i) st_d = ST_WIHI;
        else if (tmr_hit) begin
          st_d   = ST_IDLE;
          code_d = RES_NO_INIT_LOW;
        end
      end
      ST_WIHI: begin
        if (init_i) st_d = ST_SHIFT;
        else if (tmr_hit) begin
          st_d   = ST_IDLE;
          code_d = RES_NO_INIT_HIGH;
        end
      end
      ST_SHIFT: if (sh_end) st_d = ST_WDONE;
      ST_WDONE: begin
        if (done_i) st_d = ST_HOLD_LO;
        else if (tmr_hit) begin
          st_d   = ST_IDLE;
          code_d = RES_NO_DONE;
        end
      end
      ST_HOLD_LO: if (tmr_hit) st_d = ST_HOLD_HI;
      ST_HOLD_HI: if (tmr_hit) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q   <= ST_IDLE;
      code_q <= RES_OK;
    end else begin
      st_q   <= st_d;
      code_q <= code_d;
    end
  end

  assign busy_o  = (st_q != ST_IDLE);
  assign prog_o  = (st_q != ST_PLOW);
  assign ready_o = (st_q == ST_SHIFT) && sh_empty;
  assign cclk_o  = (st_q == ST_SHIFT) ? sh_cclk
                 : ((st_q == ST_HOLD_LO) || (st_q == ST_HOLD_HI));
  assign din_o   = (st_q == ST_SHIFT) ? sh_din : (st_q == ST_HOLD_HI);
  assign code_o  = code_q;

  AST_PROG_LOW_ONLY_BUSY: assert property (@(posedge clk) disable iff (!srst_n)
    !prog_o |-> busy_o); // R2

  AST_READY_ONLY_BUSY: assert property (@(posedge clk) disable iff (!srst_n)
    ready_o |-> busy_o); // R6

  AST_CODE_HELD_IDLE: assert property (@(posedge clk) disable iff (!srst_n)
    (!busy_o && !start_i) |=> $stable(code_o)); // R9

  AST_END_PINS_QUIET: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(busy_o) |-> (prog_o && !cclk_o)); // R8

endmodule

// File: tb/tb_fpga_cfg_loader.sv
module tb_fpga_cfg_loader;

  localparam int H  = 2;
  localparam int T1 = 8;
  localparam int T2 = 10;
  localparam int T3 = 12;
  localparam int HD = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] data_i = '0;
  logic       valid_i = 1'b0;
  logic       last_i = 1'b0;
  logic       init_i = 1'b1;
  logic       done_i = 1'b0;
  logic       ready_o, prog_o, cclk_o, din_o, busy_o;
  logic [1:0] code_o;

  always #2 clk = ~clk;

  fpga_cfg_loader #(
    .BYTE_W(8), .CCLK_HALF(H), .T_INIT_LOW(T1), .T_INIT_HIGH(T2),
    .T_DONE(T3), .HOLD_CYC(HD)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_i(data_i),
    .valid_i(valid_i), .last_i(last_i), .ready_o(ready_o), .prog_o(prog_o),
    .cclk_o(cclk_o), .din_o(din_o), .init_i(init_i), .done_i(done_i),
    .busy_o(busy_o), .code_o(code_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle,1 prog high,2 prog low,3 wait init high,
  // 4 data,5 wait done,6 hold din low,7 hold din high
  int m_ph = 0, m_cnt = 0, m_tick = 0, m_hold = 2, m_code = 0;
  bit m_last = 0;
  bit m_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_code = 0; m_hold = 2; m_q.delete();
    end else if (m_hold > 0) begin
      m_hold--;
    end else begin
      case (m_ph)
        0: if (start_i) begin m_ph = 1; m_code = 0; end
        1: begin m_ph = 2; m_cnt = 0; end
        2: if (!init_i) begin m_ph = 3; m_cnt = 0; end
           else if (m_cnt == T1 - 1) begin m_ph = 0; m_code = 1; end
           else m_cnt++;
        3: if (init_i) begin m_ph = 4; m_cnt = 0; end
           else if (m_cnt == T2 - 1) begin m_ph = 0; m_code = 2; end
           else m_cnt++;
        4: if (m_q.size() > 0) begin
             m_tick++;
             if (m_tick == 2 * H) begin
               void'(m_q.pop_front());
               m_tick = 0;
               if (m_q.size() == 0 && m_last) begin m_ph = 5; m_cnt = 0; end
             end
           end else if (valid_i) begin
             for (int b = 7; b >= 0; b--) m_q.push_back(data_i[b]);
             m_last = last_i;
             m_tick = 0;
           end
        5: if (done_i) begin m_ph = 6; m_cnt = 0; end
           else if (m_cnt == T3 - 1) begin m_ph = 0; m_code = 3; end
           else m_cnt++;
        6: if (m_cnt == HD - 1) begin m_ph = 7; m_cnt = 0; end else m_cnt++;
        7: if (m_cnt == HD - 1) begin m_ph = 0; m_cnt = 0; end else m_cnt++;
        default: m_ph = 0;
      endcase
    end
  end

  // every-clock comparison against the reference
  always @(negedge clk) begin
    bit sh;
    sh = (m_ph == 4) && (m_q.size() > 0);
    chk("R2/R3/R4", "prog_o", int'(prog_o), int'(m_ph != 2));
    chk("R9", "busy_o", int'(busy_o), int'(m_ph != 0));
    chk("R6", "ready_o", int'(ready_o), int'((m_ph == 4) && (m_q.size() == 0)));
    chk("R5/R8", "cclk_o", int'(cclk_o), int'((sh && m_tick >= H) || m_ph == 6 || m_ph == 7));
    chk("R5/R8", "din_o", int'(din_o), int'((sh && m_q[0]) || m_ph == 7));
    chk("R3/R4/R7/R9", "code_o", int'(code_o), m_code);
  end

  // FPGA-side receiver: collects DIN on each rising CCLK during the data phase
  bit cap[$];
  logic cclk_prev = 1'b0;
  always @(negedge clk) begin
    if (cclk_o && !cclk_prev && !done_i) cap.push_back(din_o);
    cclk_prev = cclk_o;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_prog_low();
    while (prog_o) @(negedge clk);
  endtask

  task automatic wait_prog_high();
    while (!prog_o) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit l);
    bit r;
    data_i = d; last_i = l; valid_i = 1'b1;
    do begin
      r = ready_o;
      @(negedge clk);
    end while (!r);
    valid_i = 1'b0; last_i = 1'b0;
  endtask

  // full load: INIT fall after j1, INIT rise after j2, DONE after jd cycles of waiting
  task automatic run_load(input int j1, input int j2, input int jd, input int nb,
                          input logic [7:0] seed, input bit poke_start);
    cap.delete();
    pulse_start();
    wait_prog_low();
    tick(j1);
    init_i = 1'b0;
    wait_prog_high();
    tick(j2);
    init_i = 1'b1;
    for (int i = 0; i < nb; i++) begin
      send(seed + 8'(i * 37), i == nb - 1);
      if (poke_start && i == 0) begin
        tick(3);
        pulse_start();
      end
    end
    tick(16 * H + jd);
    done_i = 1'b1;
    wait_idle();
    done_i = 1'b0;
    tick(2);
    chk("R5", "captured bit count", cap.size(), 8 * nb);
    for (int i = 0; i < nb && cap.size() == 8 * nb; i++) begin
      logic [7:0] g;
      for (int b = 0; b < 8; b++) g[7 - b] = cap[8 * i + b];
      chk("R5", "captured byte", int'(g), int'(seed + 8'(i * 37)));
    end
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R1: idle after reset
    chk("R1", "prog_o", int'(prog_o), 1);
    chk("R1", "cclk_o", int'(cclk_o), 0);
    chk("R1", "din_o", int'(din_o), 0);
    chk("R1", "ready_o", int'(ready_o), 0);
    chk("R1", "busy_o", int'(busy_o), 0);
    chk("R1", "code_o", int'(code_o), 0);

    // R5, R6, R8, R2: normal load with a stray start during shifting
    run_load(2, 3, 4, 3, 8'hA5, 1'b1);
    chk("R8", "code after good load", int'(code_o), 0);

    // R3: INIT never falls
    pulse_start();
    wait_idle();
    chk("R3", "code INIT stuck high", int'(code_o), 1);
    tick(5);
    chk("R9", "code held while idle", int'(code_o), 1);

    // R4: INIT falls but never rises
    pulse_start();
    wait_prog_low();
    tick(1);
    init_i = 1'b0;
    wait_idle();
    chk("R4", "code INIT stuck low", int'(code_o), 2);
    init_i = 1'b1;
    tick(2);

    // R10: every handshake lands on the last cycle of its window
    run_load(T1 - 1, T2 - 1, T3 - 1, 1, 8'h3C, 1'b0);
    chk("R10", "code with edge on last window cycle", int'(code_o), 0);

    // R10: INIT fall one cycle too late
    pulse_start();
    wait_prog_low();
    tick(T1);
    init_i = 1'b0;
    wait_idle();
    chk("R10", "code with INIT one cycle late", int'(code_o), 1);
    init_i = 1'b1;
    tick(2);

    // R7, R10: DONE one cycle too late, then never
    pulse_start();
    wait_prog_low();
    tick(1);
    init_i = 1'b0;
    wait_prog_high();
    init_i = 1'b1;
    send(8'h81, 1'b1);
    tick(16 * H + T3);
    done_i = 1'b1;
    wait_idle();
    done_i = 1'b0;
    chk("R7", "code DONE one cycle late", int'(code_o), 3);
    tick(3);
    pulse_start();
    chk("R9", "code cleared by start", int'(code_o), 0);
    wait_prog_low();
    init_i = 1'b0;
    wait_prog_high();
    init_i = 1'b1;
    send(8'h5A, 1'b0);
    send(8'hC3, 1'b1);
    wait_idle();
    chk("R7", "code DONE never", int'(code_o), 3);

    tick(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule